// File: doc/BRIEF.md
# Stack Allocation Limit Trap

This unit sits beside the execute-stage adder of a small RISC-V-style core and watches for stack frame creation. When the instruction in execute is an immediate add that writes x2 from x2, the unit compares the adder's result with a single machine-mode limit register. If the new stack pointer would fall below the limit, the unit asks for a synchronous exception in the same cycle. It supplies a cause code, the PC of the add and the offending address.

On that same overflow the unit takes over the stack pointer writeback, so x2 receives the limit value instead of the adder result. It also clears the limit register at the next clock edge. With checking switched off, the trap handler's own frame allocation runs freely, and the handler finds a known stack pointer. Software re-arms checking by writing a nonzero limit. A limit of zero means checking is off, and zero is the reset value. Only the add's result is examined. Loads, stores, post-increment updates and every other write to x2 are never checked.

Top module: `stack_guard_unit`

## Requirements
- R1: After reset the limit register reads 0 at its CSR address.
- R2: A CSR write whose address equals the parameter CSR_ADDR (default 0x7C0) loads the limit, and the new value is readable from the next cycle. Writes to any other address leave the limit unchanged. `csr_rdata` shows the limit when `csr_addr` equals CSR_ADDR and 0 otherwise.
- R3: An overflow is flagged when `ex_valid` and `ex_is_addi` are 1, `ex_rd` and `ex_rs1` both equal 2, the limit is nonzero, and `ex_result` is strictly below the limit. Its effects are: `exc_req` is 1 in that cycle, and `exc_cause` is 24.
- R4: During an overflow, `exc_pc` equals `ex_pc` and `exc_tval` equals `ex_result`.
- R5: During an overflow, `sp_wb_sel` is 1 and `sp_wb_data` equals the limit. Otherwise `sp_wb_sel` is 0 and `sp_wb_data` equals `ex_result`.
- R6: After a cycle with an overflow, the limit reads 0.
- R7: If a CSR write to the limit happens in the same cycle as an overflow, the clear wins and the limit reads 0 afterwards.
- R8: With a limit of 0, no instruction raises an overflow.
- R9: Instructions that do not match (not valid, not an immediate add, rd not 2, or rs1 not 2) never raise an overflow.
- R10: A result equal to the limit does not raise an overflow.
- R11: The comparison is unsigned over the full XLEN bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ex_valid | input | 1 | Execute stage holds a live instruction |
| ex_is_addi | input | 1 | Instruction is an immediate add |
| ex_rd | input | 5 | Destination register index |
| ex_rs1 | input | 5 | Source register index |
| ex_result | input | XLEN | Adder result |
| ex_pc | input | XLEN | PC of the instruction in execute |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR address, used for both read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | Limit value when the address matches, else 0 |
| exc_req | output | 1 | Synchronous exception request |
| exc_cause | output | 5 | Exception cause code |
| exc_pc | output | XLEN | Exception PC |
| exc_tval | output | XLEN | Trap value (offending stack address) |
| sp_wb_sel | output | 1 | Stack pointer writeback override |
| sp_wb_data | output | XLEN | Value to write to x2 |

## Verification
The checker tests these properties on every cycle:
- the cause code, PC and trap value go out whenever an exception is requested;
- the writeback override is raised exactly with the request, and the clamped value is strictly above the adder result;
- a request comes only from a matching x2 add;
- the limit reads zero right after any overflow.

Other behaviour needs a history of writes, so only the bench scenarios show it:
- that a CSR write at the right address takes effect while writes at other addresses do not;
- that a clear beats a simultaneous write;
- that a zero limit disarms the check;
- that equality does not trap;
- that values with the top bit set compare as unsigned.

// File: rtl/stklim_pkg.sv
package stklim_pkg;

    localparam int unsigned REG_IDX_W   = 5;
    localparam int unsigned CAUSE_W     = 5;
    localparam logic [REG_IDX_W-1:0] SP_IDX = 5'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_STACK_OVF = 5'd24;

    typedef struct packed {
        logic                 valid;
        logic                 is_addi;
        logic [REG_IDX_W-1:0] rd;
        logic [REG_IDX_W-1:0] rs1;
    } ex_op_t;

    function automatic logic is_sp_alloc(input ex_op_t op);
        return op.valid && op.is_addi && (op.rd == SP_IDX) && (op.rs1 == SP_IDX);
    endfunction

endpackage

// File: rtl/stklim_csr.sv
module stklim_csr #(
    parameter int unsigned XLEN     = 32,
    parameter logic [11:0] CSR_ADDR = 12'h7C0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [11:0]     addr,
    input  logic [XLEN-1:0] wdata,
    input  logic            clr,
    output logic [XLEN-1:0] limit,
    output logic [XLEN-1:0] rdata
);
    logic sel;
    assign sel = (addr == CSR_ADDR);

    // Clear from an overflow outranks a software write in the same cycle.
    always_ff @(posedge clk) begin
        if (rst)
            limit <= '0;
        else if (clr)
            limit <= '0;
        else if (we && sel)
            limit <= wdata;
    end

    assign rdata = sel ? limit : '0;
endmodule

// File: rtl/stklim_detect.sv
module stklim_detect
    import stklim_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  ex_op_t          op,
    input  logic [XLEN-1:0] result,
    input  logic [XLEN-1:0] limit,
    output logic            ovf
);
    logic armed;
    logic below;

    assign armed = (limit != '0);
    assign below = (result < limit);   // both unsigned
    assign ovf   = is_sp_alloc(op) && armed && below;
endmodule

// File: rtl/stklim_resp.sv
module stklim_resp
    import stklim_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic               ovf,
    input  logic [XLEN-1:0]    result,
    input  logic [XLEN-1:0]    pc,
    input  logic [XLEN-1:0]    limit,
    output logic               req,
    output logic [CAUSE_W-1:0] cause,
    output logic [XLEN-1:0]    epc,
    output logic [XLEN-1:0]    tval,
    output logic               wb_sel,
    output logic [XLEN-1:0]    wb_data
);
    always_comb begin
        req     = ovf;
        cause   = ovf ? CAUSE_STACK_OVF : '0;
        epc     = ovf ? pc : '0;
        tval    = ovf ? result : '0;
        wb_sel  = ovf;
        wb_data = ovf ? limit : result;
    end
endmodule

// File: rtl/stack_guard_unit.sv
module stack_guard_unit
    import stklim_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter logic [11:0] CSR_ADDR = 12'h7C0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ex_valid,
    input  logic               ex_is_addi,
    input  logic [4:0]         ex_rd,
    input  logic [4:0]         ex_rs1,
    input  logic [XLEN-1:0]    ex_result,
    input  logic [XLEN-1:0]    ex_pc,
    input  logic               csr_we,
    input  logic [11:0]        csr_addr,
    input  logic [XLEN-1:0]    csr_wdata,
    output logic [XLEN-1:0]    csr_rdata,
    output logic               exc_req,
    output logic [CAUSE_W-1:0] exc_cause,
    output logic [XLEN-1:0]    exc_pc,
    output logic [XLEN-1:0]    exc_tval,
    output logic               sp_wb_sel,
    output logic [XLEN-1:0]    sp_wb_data
);
    ex_op_t          op;
    logic [XLEN-1:0] limit;
    logic            ovf;

    assign op = '{valid: ex_valid, is_addi: ex_is_addi, rd: ex_rd, rs1: ex_rs1};

    stklim_csr #(.XLEN(XLEN), .CSR_ADDR(CSR_ADDR)) u_csr (
        .clk   (clk),
        .rst   (rst),
        .we    (csr_we),
        .addr  (csr_addr),
        .wdata (csr_wdata),
        .clr   (ovf),
        .limit (limit),
        .rdata (csr_rdata)
    );

    stklim_detect #(.XLEN(XLEN)) u_detect (
        .op     (op),
        .result (ex_result),
        .limit  (limit),
        .ovf    (ovf)
    );

    stklim_resp #(.XLEN(XLEN)) u_resp (
        .ovf     (ovf),
        .result  (ex_result),
        .pc      (ex_pc),
        .limit   (limit),
        .req     (exc_req),
        .cause   (exc_cause),
        .epc     (exc_pc),
        .tval    (exc_tval),
        .wb_sel  (sp_wb_sel),
        .wb_data (sp_wb_data)
    );
endmodule

// File: rtl/stack_guard_unit_chk.sv
module stack_guard_unit_chk #(
    parameter int unsigned XLEN     = 32,
    parameter logic [11:0] CSR_ADDR = 12'h7C0
) (
    input logic            clk,
    input logic            rst,
    input logic            ex_valid,
    input logic            ex_is_addi,
    input logic [4:0]      ex_rd,
    input logic [4:0]      ex_rs1,
    input logic [XLEN-1:0] ex_result,
    input logic [XLEN-1:0] ex_pc,
    input logic [11:0]     csr_addr,
    input logic [XLEN-1:0] csr_rdata,
    input logic            exc_req,
    input logic [4:0]      exc_cause,
    input logic [XLEN-1:0] exc_pc,
    input logic [XLEN-1:0] exc_tval,
    input logic            sp_wb_sel,
    input logic [XLEN-1:0] sp_wb_data
);
    p_reset_zero_r1: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && csr_addr == CSR_ADDR) |-> (csr_rdata == '0));

    p_cause_r3: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (exc_cause == 5'd24));

    p_fields_r4: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (exc_pc == ex_pc && exc_tval == ex_result));

    p_clamp_r5: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (sp_wb_sel && ex_result < sp_wb_data));

    p_pass_r5: assert property (@(posedge clk) disable iff (rst)
        !exc_req |-> (!sp_wb_sel && sp_wb_data == ex_result));

    p_disarm_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(exc_req) && csr_addr == CSR_ADDR) |-> (csr_rdata == '0));

    p_match_only_r9: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (ex_valid && ex_is_addi && ex_rd == 5'd2 && ex_rs1 == 5'd2));

    p_strict_r10: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (ex_result != sp_wb_data));
endmodule

bind stack_guard_unit stack_guard_unit_chk #(.XLEN(XLEN), .CSR_ADDR(CSR_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ex_valid   (ex_valid),
    .ex_is_addi (ex_is_addi),
    .ex_rd      (ex_rd),
    .ex_rs1     (ex_rs1),
    .ex_result  (ex_result),
    .ex_pc      (ex_pc),
    .csr_addr   (csr_addr),
    .csr_rdata  (csr_rdata),
    .exc_req    (exc_req),
    .exc_cause  (exc_cause),
    .exc_pc     (exc_pc),
    .exc_tval   (exc_tval),
    .sp_wb_sel  (sp_wb_sel),
    .sp_wb_data (sp_wb_data)
);

// File: tb/stack_guard_unit_tb.sv
module stack_guard_unit_tb;
    localparam int unsigned XLEN   = 32;
    localparam logic [11:0] CADDR  = 12'h7C0;
    localparam time         CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ex_valid = 1'b0, ex_is_addi = 1'b0;
    logic [4:0]      ex_rd = '0, ex_rs1 = '0;
    logic [XLEN-1:0] ex_result = '0, ex_pc = '0;
    logic            csr_we = 1'b0;
    logic [11:0]     csr_addr = CADDR;
    logic [XLEN-1:0] csr_wdata = '0;
    logic [XLEN-1:0] csr_rdata, exc_pc, exc_tval, sp_wb_data;
    logic            exc_req, sp_wb_sel;
    logic [4:0]      exc_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [XLEN-1:0] m_lim = '0;
    bit prev_ovf = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stack_guard_unit #(.XLEN(XLEN), .CSR_ADDR(CADDR)) u_dut (
        .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_is_addi(ex_is_addi),
        .ex_rd(ex_rd), .ex_rs1(ex_rs1), .ex_result(ex_result), .ex_pc(ex_pc),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .exc_req(exc_req), .exc_cause(exc_cause),
        .exc_pc(exc_pc), .exc_tval(exc_tval), .sp_wb_sel(sp_wb_sel),
        .sp_wb_data(sp_wb_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit exp_ovf(input bit v, input bit a, input logic [4:0] rd,
                                   input logic [4:0] rs, input logic [XLEN-1:0] res,
                                   input logic [XLEN-1:0] lim);
        return v && a && rd == 5'd2 && rs == 5'd2 && lim != '0 && res < lim;
    endfunction

    // Drive one cycle, check outputs mid-cycle, then update the model at the edge.
    task automatic cyc(input bit v, input bit a, input logic [4:0] rd, input logic [4:0] rs,
                       input logic [XLEN-1:0] res, input logic [XLEN-1:0] pc,
                       input bit we, input logic [11:0] ad, input logic [XLEN-1:0] wd);
        bit e;
        string tag;
        @(negedge clk);
        ex_valid = v; ex_is_addi = a; ex_rd = rd; ex_rs1 = rs;
        ex_result = res; ex_pc = pc; csr_we = we; csr_addr = ad; csr_wdata = wd;
        #1;
        e = exp_ovf(v, a, rd, rs, res, m_lim);
        if (m_lim == '0) tag = "R8";
        else if (!(v && a && rd == 5'd2 && rs == 5'd2)) tag = "R9";
        else if (res == m_lim) tag = "R10";
        else if (res[XLEN-1] != m_lim[XLEN-1]) tag = "R11";
        else tag = "R3";
        chk(exc_req == e, tag, {31'd0, exc_req}, {31'd0, e});
        if (e) begin
            chk(exc_cause == 5'd24, "R3", {27'd0, exc_cause}, 32'd24);
            chk(exc_pc == pc && exc_tval == res, "R4", exc_tval, res);
            chk(sp_wb_sel && sp_wb_data == m_lim, "R5", sp_wb_data, m_lim);
        end else begin
            chk(!sp_wb_sel && sp_wb_data == res, "R5", sp_wb_data, res);
        end
        if (ad == CADDR)
            chk(csr_rdata == m_lim, prev_ovf ? "R6" : "R2", csr_rdata, m_lim);
        @(posedge clk);
        if (e) m_lim = '0;
        else if (we && ad == CADDR) m_lim = wd;
        prev_ovf = e;
    endtask

    task automatic idle_rd(input logic [11:0] ad);
        cyc(1'b0, 1'b0, 5'd0, 5'd0, 32'h0, 32'h0, 1'b0, ad, 32'h0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [XLEN-1:0] r;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk(csr_rdata == '0, "R1", csr_rdata, 32'h0);
        chk(!exc_req, "R1", {31'd0, exc_req}, 32'h0);
        // R8: disarmed, small result does not trap
        cyc(1, 1, 2, 2, 32'h0, 32'h100, 0, CADDR, 0);
        // R2: write elsewhere ignored, then write the limit
        cyc(0, 0, 0, 0, 0, 0, 1, 12'h7C1, 32'h5);
        idle_rd(CADDR);
        chk(csr_rdata == '0, "R2", csr_rdata, 32'h0);
        cyc(0, 0, 0, 0, 0, 0, 1, CADDR, 32'h1000);
        idle_rd(CADDR);
        chk(csr_rdata == 32'h1000, "R2", csr_rdata, 32'h1000);
        idle_rd(12'h7C1);
        chk(csr_rdata == '0, "R2", csr_rdata, 32'h0);
        // R10: equality passes; R9: non-matching forms
        cyc(1, 1, 2, 2, 32'h1000, 32'h200, 0, CADDR, 0);
        cyc(1, 1, 3, 2, 32'h10, 32'h204, 0, CADDR, 0);
        cyc(1, 1, 2, 5, 32'h10, 32'h208, 0, CADDR, 0);
        cyc(1, 0, 2, 2, 32'h10, 32'h20C, 0, CADDR, 0);
        cyc(0, 1, 2, 2, 32'h10, 32'h210, 0, CADDR, 0);
        // R3/R4/R5: overflow, then R6 disarm
        cyc(1, 1, 2, 2, 32'h0FFC, 32'h300, 0, CADDR, 0);
        idle_rd(CADDR);
        chk(csr_rdata == '0, "R6", csr_rdata, 32'h0);
        cyc(1, 1, 2, 2, 32'h10, 32'h304, 0, CADDR, 0);
        // R7: clear beats a same-cycle write
        cyc(0, 0, 0, 0, 0, 0, 1, CADDR, 32'h2000);
        cyc(1, 1, 2, 2, 32'h1F00, 32'h400, 1, CADDR, 32'h3000);
        idle_rd(CADDR);
        chk(csr_rdata == '0, "R7", csr_rdata, 32'h0);
        // R11: unsigned compare across the top bit
        cyc(0, 0, 0, 0, 0, 0, 1, CADDR, 32'h8000_0000);
        cyc(1, 1, 2, 2, 32'hFFFF_FFF0, 32'h500, 0, CADDR, 0);
        chk(!prev_ovf, "R11", {31'd0, prev_ovf}, 32'h0);
        cyc(1, 1, 2, 2, 32'h7FFF_FFFF, 32'h504, 0, CADDR, 0);
        chk(prev_ovf, "R11", {31'd0, prev_ovf}, 32'h1);
        // Random mix
        for (int i = 0; i < 2000; i++) begin
            bit w;
            w = ($urandom % 6) == 0;
            r = m_lim + ($urandom % 64) - 32;
            if (($urandom % 8) == 0) r = $urandom;
            cyc(($urandom % 8) != 0, ($urandom % 4) != 0,
                (($urandom % 4) != 0) ? 5'd2 : 5'($urandom),
                (($urandom % 4) != 0) ? 5'd2 : 5'($urandom),
                r, $urandom & 32'hFFFF_FFFC, w,
                (($urandom % 5) != 0) ? CADDR : 12'h7C0 + 12'($urandom % 4),
                (($urandom % 8) == 0) ? 32'h0 : ($urandom & 32'h000F_FFF0) | 32'h100);
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule